// File: doc/BRIEF.md
# Capture-Compare Timer with Pulse Generation

A 16-bit counting timer for a microcontroller-style peripheral set. The counter advances on ticks from a selectable source: the system clock divided by 2, 4 or 8, or edges of an external clock input. Two compare registers watch the count. In plain compare mode each compare register sets its own output level when it matches. In pulse-width mode, compare 1 becomes the pulse width and compare 2 becomes the period. In one-pulse mode, an edge on the first capture input starts a single pulse whose length is set by compare 1. Two capture inputs copy the current count into capture registers on a chosen edge.

Software reaches the block through a write port and a combinational read port. The output-enable bits only decide whether a compare level reaches its pin. The compare logic keeps running whatever those bits hold. Two parameters remove hardware that a given chip instance lacks: one removes the external clock input, the other removes the second pin enable.

Top module: `cc_timer16`

## Requirements
- R1: While rst_n is low, the control register and the level register read 0, the counter reads 0, both pin levels are 0 and both output enables are 0.
- R2: Control bits [3:2] select the tick source. 00 gives one count per 4 clk cycles, 01 one count per 2, and 10 one count per 8. The counter advances by exactly one per tick.
- R3: With control bits [3:2] = 11, the counter advances once per edge of ext_clk after a two-flop synchronizer. Control bit 0 = 1 selects rising edges and 0 selects falling edges. The other edge has no effect. ext_clk must toggle slower than clk/2.
- R4: When HAS_EXT_CLK = 0 and bits [3:2] = 11, the counter holds its value whatever ext_clk does.
- R5: In plain compare mode (bits 5 and 4 both 0), a tick taken while the count equals compare 1 sets cmp1_pin to level bit 0. A tick taken while the count equals compare 2 sets cmp2_pin to level bit 1.
- R6: Control bit 7 drives cmp1_oe and bit 6 drives cmp2_oe. These bits do not affect the pin levels, which keep following the compare logic while the enables are 0.
- R7: When HAS_CMP2_PIN = 0, control bit 6 reads back 0 and cmp2_oe stays 0.
- R8: Pulse-width mode (bit 4 = 1, taking precedence over bit 5): a tick taken at a count at or above compare 2 reloads the counter to RELOAD_VAL and sets cmp1_pin to level bit 0. A tick at a count equal to compare 1 sets cmp1_pin to level bit 1.
- R9: In pulse-width mode with compare 1 at or above compare 2, cmp1_pin stays at level bit 0.
- R10: One-pulse mode (bit 5 = 1, bit 4 = 0): an active edge on cap1_in reloads the counter to RELOAD_VAL and sets cmp1_pin to level bit 0. Level bit 2 = 1 makes rising the active edge and 0 makes falling the active edge. The next tick at a count equal to compare 1 sets cmp1_pin to level bit 1.
- R11: An active edge on cap2_in copies the count into capture 2. Control bit 1 = 1 selects rising and 0 selects falling. The opposite edge leaves capture 2 unchanged. cap1_in fills capture 1 the same way on its level-bit-2 edge.
- R12: Register addresses are: 0 control (low 8 bits), 1 compare 1, 2 compare 2, 3 levels (bits 2:0), 4 count, 5 capture 1, 6 capture 2. Addresses 0 to 3 read back what was written. Writes to addresses 4 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | W | Register read data, combinational |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap1_in | input | 1 | Capture 1 and one-pulse trigger, asynchronous |
| cap2_in | input | 1 | Capture 2 input, asynchronous |
| cmp1_pin | output | 1 | Compare 1 / waveform level |
| cmp1_oe | output | 1 | Pin enable for cmp1_pin |
| cmp2_pin | output | 1 | Compare 2 level |
| cmp2_oe | output | 1 | Pin enable for cmp2_pin |

## Verification
A wrong prescaler phase or divide value shows within one 64-cycle window as a wrong count difference read through the count register. A counter that misses its reload in pulse-width mode shows in the same period, as a read count above compare 2 and a duty cycle that drifts from 8 high cycles in 20. Synchronizer or edge-selection faults appear a few cycles after an input edge, either as a count or capture value that moves when it should hold, or as one that holds when it should move. A one-pulse fault shows as a pulse whose length falls outside one tick of the programmed length.

// File: rtl/cc_timer16_pkg.sv
// Shared types and register addresses of the capture-compare timer.
// Assumes a byte-wide control register whose bit order software relies on.
package cc_timer16_pkg;

    typedef enum logic [1:0] {
        CLK_DIV4 = 2'b00,
        CLK_DIV2 = 2'b01,
        CLK_DIV8 = 2'b10,
        CLK_EXT  = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic     pin1_en;
        logic     pin2_en;
        logic     one_shot;
        logic     pwm_en;
        clk_sel_e clk_sel;
        logic     cap2_rise;
        logic     ext_rise;
    } ctrl_t;

    typedef struct packed {
        logic cap1_rise;
        logic lvl_b;
        logic lvl_a;
    } level_t;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_CMP1  = 3'd1;
    localparam logic [2:0] ADDR_CMP2  = 3'd2;
    localparam logic [2:0] ADDR_LEVEL = 3'd3;
    localparam logic [2:0] ADDR_COUNT = 3'd4;
    localparam logic [2:0] ADDR_CAP1  = 3'd5;
    localparam logic [2:0] ADDR_CAP2  = 3'd6;

endpackage

// File: rtl/tmr_sync_edge.sv
// Brings an asynchronous input into the clk domain through STAGES flops
// and flags its rising and falling edges for one cycle each.
// Assumes the input holds each level for more than two clk cycles.
module tmr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] shreg;

    // Shift the input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], din};
    end

    assign rise =  shreg[STAGES-1] & ~shreg[STAGES];
    assign fall = ~shreg[STAGES-1] &  shreg[STAGES];
endmodule

// File: rtl/tmr_prescale.sv
// Produces a one-cycle count tick from the selected source: clk divided
// by 2, 4 or 8, or a synchronized external edge. When HAS_EXT is 0 the
// external choice yields no tick, so the counter stops.
module tmr_prescale
    import cc_timer16_pkg::*;
#(
    parameter bit HAS_EXT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_e sel,
    input  logic     ext_rise_sel,
    input  logic     ext_rise,
    input  logic     ext_fall,
    output logic     tick
);
    logic [2:0] div_cnt;
    logic       ext_tick;

    // Free-running divider shared by all internal rates.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 3'd1;
    end

    generate
        if (HAS_EXT) begin : g_ext
            assign ext_tick = ext_rise_sel ? ext_rise : ext_fall;
        end else begin : g_noext
            assign ext_tick = 1'b0;
        end
    endgenerate

    // Pick the tick source named by the clock select field.
    always_comb begin
        unique case (sel)
            CLK_DIV2: tick = div_cnt[0];
            CLK_DIV4: tick = &div_cnt[1:0];
            CLK_DIV8: tick = &div_cnt;
            default:  tick = ext_tick;
        endcase
    end

    // R2
    div2_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CLK_DIV2 && tick) |=> (sel != CLK_DIV2 || !tick));
    // R2
    div4_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CLK_DIV4 && tick) |=> (sel != CLK_DIV4 || !tick));
endmodule

// File: rtl/tmr_core.sv
// Counter, compare matching, waveform levels and capture registers.
// Assumes tick, trig1 and trig2 are single-cycle pulses in the clk domain.
// Pulse-width mode takes precedence over one-pulse mode.
module tmr_core #(
    parameter int          W          = 16,
    parameter logic [W-1:0] RELOAD_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm_en,
    input  logic         one_shot,
    input  logic         lvl_a,
    input  logic         lvl_b,
    input  logic [W-1:0] cmp1,
    input  logic [W-1:0] cmp2,
    input  logic         trig1,
    input  logic         trig2,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap1_val,
    output logic [W-1:0] cap2_val,
    output logic         out1,
    output logic         out2
);
    logic osm, osm_start, hit1, hit2, period_hit;

    assign osm        = one_shot & ~pwm_en;
    assign osm_start  = osm & trig1;
    assign hit1       = tick && (cnt == cmp1);
    assign hit2       = tick && (cnt == cmp2);
    assign period_hit = tick && (cnt >= cmp2);

    // Advance the count, reloading at the period or a one-pulse start.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (pwm_en && period_hit)  cnt <= RELOAD_VAL;
        else if (osm_start)             cnt <= RELOAD_VAL;
        else if (tick)                  cnt <= cnt + 1'b1;
    end

    // Drive the first output level according to the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                      out1 <= 1'b0;
        else if (pwm_en) begin
            if (period_hit)              out1 <= lvl_a;
            else if (hit1)               out1 <= lvl_b;
        end else if (osm) begin
            if (trig1)                   out1 <= lvl_a;
            else if (hit1)               out1 <= lvl_b;
        end else if (hit1)               out1 <= lvl_a;
    end

    // Second compare keeps its own level in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n)    out2 <= 1'b0;
        else if (hit2) out2 <= lvl_b;
    end

    // Latch the count on each capture trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap1_val <= '0;
            cap2_val <= '0;
        end else begin
            if (trig1) cap1_val <= cnt;
            if (trig2) cap2_val <= cnt;
        end
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pwm_en && !osm_start) |=> (cnt == W'($past(cnt) + 1'b1)));
    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !osm_start) |=> $stable(cnt));
    // R8
    pwm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && tick && cnt >= cmp2) |=> (cnt == RELOAD_VAL && out1 == $past(lvl_a)));
    // R10
    one_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osm_start |=> (cnt == RELOAD_VAL && out1 == $past(lvl_a)));
    // R11
    capture2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig2 |=> (cap2_val == $past(cnt)));
endmodule

// File: rtl/cc_timer16.sv
// Top of the capture-compare timer: registers, read mux, input
// synchronizers, prescaler and core. Assumes W >= 8. HAS_EXT_CLK and
// HAS_CMP2_PIN remove the external clock and the second pin enable.
module cc_timer16
    import cc_timer16_pkg::*;
#(
    parameter int           W            = 16,
    parameter bit           HAS_EXT_CLK  = 1'b1,
    parameter bit           HAS_CMP2_PIN = 1'b1,
    parameter logic [W-1:0] RELOAD_VAL   = '0,
    parameter int           SYNC_STAGES  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         ext_clk,
    input  logic         cap1_in,
    input  logic         cap2_in,
    output logic         cmp1_pin,
    output logic         cmp1_oe,
    output logic         cmp2_pin,
    output logic         cmp2_oe
);
    localparam int N_IN = 3;

    ctrl_t          ctrl, ctrl_nxt;
    level_t         lvl;
    logic [W-1:0]   cmp1_r, cmp2_r, cnt, cap1_val, cap2_val;
    logic [N_IN-1:0] raw_in, in_rise, in_fall;
    logic           tick, trig1, trig2;

    // Mask the second pin enable when that pin does not exist.
    always_comb begin
        ctrl_nxt         = ctrl_t'(wr_data[7:0]);
        ctrl_nxt.pin2_en = ctrl_nxt.pin2_en & HAS_CMP2_PIN;
    end

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            lvl    <= '0;
            cmp1_r <= '0;
            cmp2_r <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:  ctrl   <= ctrl_nxt;
                ADDR_CMP1:  cmp1_r <= wr_data;
                ADDR_CMP2:  cmp2_r <= wr_data;
                ADDR_LEVEL: lvl    <= level_t'(wr_data[2:0]);
                default:    ;
            endcase
        end
    end

    assign raw_in = {cap2_in, cap1_in, ext_clk};

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_sync
            tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .din(raw_in[i]),
                .rise(in_rise[i]), .fall(in_fall[i])
            );
        end
    endgenerate

    assign trig1 = lvl.cap1_rise  ? in_rise[1] : in_fall[1];
    assign trig2 = ctrl.cap2_rise ? in_rise[2] : in_fall[2];

    tmr_prescale #(.HAS_EXT(HAS_EXT_CLK)) u_presc (
        .clk(clk), .rst_n(rst_n), .sel(ctrl.clk_sel),
        .ext_rise_sel(ctrl.ext_rise), .ext_rise(in_rise[0]),
        .ext_fall(in_fall[0]), .tick(tick)
    );

    tmr_core #(.W(W), .RELOAD_VAL(RELOAD_VAL)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .pwm_en(ctrl.pwm_en), .one_shot(ctrl.one_shot),
        .lvl_a(lvl.lvl_a), .lvl_b(lvl.lvl_b),
        .cmp1(cmp1_r), .cmp2(cmp2_r), .trig1(trig1), .trig2(trig2),
        .cnt(cnt), .cap1_val(cap1_val), .cap2_val(cap2_val),
        .out1(cmp1_pin), .out2(cmp2_pin)
    );

    assign cmp1_oe = ctrl.pin1_en;
    assign cmp2_oe = ctrl.pin2_en;

    // Combinational register read.
    always_comb begin
        case (rd_addr)
            ADDR_CTRL:  rd_data = {{(W-8){1'b0}}, ctrl};
            ADDR_CMP1:  rd_data = cmp1_r;
            ADDR_CMP2:  rd_data = cmp2_r;
            ADDR_LEVEL: rd_data = {{(W-3){1'b0}}, lvl};
            ADDR_COUNT: rd_data = cnt;
            ADDR_CAP1:  rd_data = cap1_val;
            ADDR_CAP2:  rd_data = cap2_val;
            default:    rd_data = '0;
        endcase
    end

    // R6
    pin1_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL) |=> (cmp1_oe == $past(wr_data[7])));
    // R7
    pin2_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && !wr_data[6]) |=> !cmp2_oe);
endmodule

// File: tb/cc_timer16_test.sv
`timescale 1ns/1ps
module cc_timer16_test;
    import cc_timer16_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data, nx_rd_data;
    logic        ext_clk = 1'b0, cap1_in = 1'b0, cap2_in = 1'b0;
    logic        cmp1_pin, cmp1_oe, cmp2_pin, cmp2_oe;
    logic        nx_p1, nx_oe1, nx_p2, nx_oe2;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cc_timer16 uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_clk(ext_clk), .cap1_in(cap1_in), .cap2_in(cap2_in),
        .cmp1_pin(cmp1_pin), .cmp1_oe(cmp1_oe),
        .cmp2_pin(cmp2_pin), .cmp2_oe(cmp2_oe)
    );

    cc_timer16 #(.HAS_EXT_CLK(1'b0), .HAS_CMP2_PIN(1'b0)) uut_nx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(nx_rd_data),
        .ext_clk(ext_clk), .cap1_in(cap1_in), .cap2_in(cap2_in),
        .cmp1_pin(nx_p1), .cmp1_oe(nx_oe1),
        .cmp2_pin(nx_p2), .cmp2_oe(nx_oe2)
    );

    // {clock select, expected count advance over 64 cycles}
    localparam logic [17:0] DIV_VEC [3] = '{
        {2'b00, 16'd16}, {2'b01, 16'd32}, {2'b10, 16'd8}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v, output logic [15:0] nv);
        rd_addr = a;
        #1;
        v  = rd_data;
        nv = nx_rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v0, v1, n0, n1, c;
        int ones, mx;

        // R1: reset state
        wait_cyc(4);
        rd(ADDR_CTRL, v0, n0);   chk("R1 ctrl", v0, 0);
        rd(ADDR_LEVEL, v0, n0);  chk("R1 level", v0, 0);
        rd(ADDR_COUNT, v0, n0);  chk("R1 count", v0, 0);
        chk("R1 pins/oe", {cmp1_pin, cmp1_oe, cmp2_pin, cmp2_oe}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R12: readback and ignored count write
        wr(ADDR_CMP1, 16'h1234);
        rd(ADDR_CMP1, v0, n0);   chk("R12 cmp1 readback", v0, 16'h1234);
        wr(ADDR_CTRL, 16'h0008); // stop-free: /8
        rd(ADDR_COUNT, v0, n0);
        wr(ADDR_COUNT, 16'hF000);
        rd(ADDR_COUNT, v1, n1);  chk_rng("R12 count write ignored", int'(v1 - v0), 0, 2);

        // R2: prescaler table
        for (int i = 0; i < 3; i++) begin
            wr(ADDR_CTRL, {12'h0, DIV_VEC[i][17:16], 2'b00});
            wait_cyc(10);
            rd(ADDR_COUNT, v0, n0);
            wait_cyc(64);
            rd(ADDR_COUNT, v1, n1);
            chk($sformatf("R2 divider sel %0d", DIV_VEC[i][17:16]), int'(16'(v1 - v0)), int'(DIV_VEC[i][15:0]));
        end

        // R3/R4: external clock, rising edges
        wr(ADDR_CTRL, 16'h000D);
        wait_cyc(6);
        rd(ADDR_COUNT, v0, n0);
        for (int p = 0; p < 5; p++) begin
            ext_clk = 1'b1; wait_cyc(4);
            ext_clk = 1'b0; wait_cyc(4);
        end
        wait_cyc(6);
        rd(ADDR_COUNT, v1, n1);
        chk("R3 rising ext edges", int'(16'(v1 - v0)), 5);
        chk("R4 no ext clock holds", int'(16'(n1 - n0)), 0);
        // R3: falling select ignores a rising edge
        wr(ADDR_CTRL, 16'h000C);
        wait_cyc(4);
        rd(ADDR_COUNT, v0, n0);
        ext_clk = 1'b1; wait_cyc(8);
        rd(ADDR_COUNT, v1, n1);
        chk("R3 rising ignored", int'(16'(v1 - v0)), 0);
        ext_clk = 1'b0; wait_cyc(8);
        rd(ADDR_COUNT, v1, n1);
        chk("R3 falling counted", int'(16'(v1 - v0)), 1);

        // R5/R6: plain compare, pins disabled
        wr(ADDR_CTRL, 16'h0004);
        rd(ADDR_COUNT, c, n0);
        wr(ADDR_CMP1, c + 16'd40);
        wr(ADDR_CMP2, c + 16'd60);
        wr(ADDR_LEVEL, 16'h0003);
        wait_cyc(50);
        chk("R5 before matches", {cmp1_pin, cmp2_pin}, 0);
        wait_cyc(50);
        chk("R5 after cmp1 match", {cmp1_pin, cmp2_pin}, 2'b10);
        chk("R6 level moves with enable off", {cmp1_oe, cmp1_pin}, 2'b01);
        wait_cyc(60);
        chk("R5 after cmp2 match", {cmp1_pin, cmp2_pin}, 2'b11);
        wr(ADDR_CTRL, 16'h00C4);
        chk("R6 enables on", {cmp1_oe, cmp2_oe}, 2'b11);
        chk("R7 absent pin2 enable", nx_oe2, 0);
        rd(ADDR_CTRL, v0, n0);
        chk("R7 bit6 reads 0", n0, 16'h0084);

        // R8: PWM width 4 ticks of period 10 at /2
        wr(ADDR_CMP1, 16'd3);
        wr(ADDR_CMP2, 16'd9);
        wr(ADDR_LEVEL, 16'h0001);
        wr(ADDR_CTRL, 16'h0094);
        wait_cyc(40);
        rd_addr = ADDR_COUNT;
        ones = 0; mx = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); #1;
            ones += cmp1_pin;
            if (int'(rd_data) > mx) mx = int'(rd_data);
        end
        chk("R8 PWM high cycles", ones, 80);
        chk_rng("R8 count bounded by period", mx, 0, 9);

        // R9: width at or beyond period keeps level A
        wr(ADDR_CMP1, 16'd12);
        wait_cyc(40);
        ones = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); ones += cmp1_pin;
        end
        chk("R9 constant level", ones, 200);

        // R10: one-pulse on rising cap1
        wr(ADDR_CMP1, 16'd5);
        wr(ADDR_LEVEL, 16'h0005);
        wr(ADDR_CTRL, 16'h00A4);
        cap1_in = 1'b1; wait_cyc(4); cap1_in = 1'b0;
        wait_cyc(40);
        chk("R10 idle level B", cmp1_pin, 0);
        @(negedge clk); cap1_in = 1'b1;
        ones = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); ones += cmp1_pin;
        end
        chk_rng("R10 pulse length", ones, 10, 13);
        cap1_in = 1'b0; wait_cyc(10);
        chk("R10 falling edge no pulse", cmp1_pin, 0);

        // R11: capture 2 on falling, then rising
        wr(ADDR_CTRL, 16'h0004);
        rd(ADDR_CAP2, v0, n0);
        cap2_in = 1'b1; wait_cyc(6);
        rd(ADDR_CAP2, v1, n1);
        chk("R11 rising ignored", v1, v0);
        cap2_in = 1'b0; wait_cyc(6);
        rd(ADDR_CAP2, v1, n1);
        rd(ADDR_COUNT, c, n0);
        chk_rng("R11 falling captured", int'(16'(c - v1)), 1, 5);
        wr(ADDR_CTRL, 16'h0006);
        cap2_in = 1'b1; wait_cyc(6);
        rd(ADDR_CAP2, v1, n1);
        rd(ADDR_COUNT, c, n0);
        chk_rng("R11 rising captured", int'(16'(c - v1)), 1, 5);
        cap2_in = 1'b0; wait_cyc(6);
        rd(ADDR_CAP2, v0, n0);
        chk("R11 falling ignored", v0, v1);
        rd(ADDR_CAP1, v0, n0);
        chk_rng("R11 capture 1 filled", int'(v0 != 0), 1, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule